// File: doc/BRIEF.md
# Euler Step Engine for a Coupled Volume/Flow Compartment

This block advances the state of one airway compartment of a physical model by a single explicit Euler timestep each time it is started. The compartment has two state words: a volume-like value and a flow-like value. The volume changes at the rate of the difference between the inflow and the outflow. The flow changes at the rate of the pressure difference, less a damping term formed from the flow times a resistance constant times an inertance constant. Each rate is scaled by the timestep and added to its state.

A microsequenced controller does the arithmetic with one shared multiplier and one shared subtractor. Four operand multiplexers pick each operand from the captured port inputs, a small constant table, the two-word state store, or the controller's scratch registers. To add a scaled rate to a state, the controller negates the scaled rate and then subtracts it, so no adder is needed. All values are signed Q16.16. The block is meant to run as one tile of a larger real-time emulation fabric. The neighbour flows and pressures are presented on the ports, `start_i` is pulsed, and the new state is read when `done_o` pulses.

Top module: `ode_euler_pe`

## Requirements
- R1: While `rst` is high at a clock edge, the state is loaded with the initial values (`V0_Q` for volume, `F0_Q` for flow), and `busy_o` and `done_o` go low at that edge.
- R2: After one step, the volume output equals V + qmul(FA − FB, DT). FA is `fa_i` and FB is `fb_i`. DT is the timestep constant.
- R3: After one step, the flow output equals F + qmul((P1 − P2) − qmul(qmul(F, CR), CL), DT). F is the flow held before the step.
- R4: qmul(a, b) is the full signed 64-bit product of two Q16.16 words, shifted arithmetically right by 16 bits, keeping the low 32 bits. This rounds toward minus infinity. Every subtraction wraps modulo 2^32.
- R5: `done_o` is high for exactly one cycle, at the 12th rising edge counting the edge that samples `start_i` as the first. `busy_o` is high from the next edge through the cycle in which `done_o` is high.
- R6: A `start_i` pulse that arrives while `busy_o` is high has no effect. It does not change the result of the step in progress, and it does not produce a further `done_o`.
- R7: The four neighbour inputs are captured at the edge that accepts `start_i`. Changes to them later in the step do not affect the result.
- R8: The state is kept between steps, so N consecutive steps give the same result as N iterations of the update in R2 and R3.
- R9: While the block is idle, `v_o` and `f_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the initial state |
| start_i | input | 1 | Single-cycle request to run one timestep |
| p1_i | input | W | Upstream pressure, Q16.16 |
| p2_i | input | W | Downstream pressure, Q16.16 |
| fa_i | input | W | Flow into the compartment, Q16.16 |
| fb_i | input | W | Flow out of the compartment, Q16.16 |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle pulse when the new state is valid |
| v_o | output | W | Stored volume state, Q16.16 |
| f_o | output | W | Stored flow state, Q16.16 |

## Verification
The hardest situation to reach from the ports is a disturbance in the middle of a step. This means a second start, or new neighbour values, arriving while the sequencer is partway through its micro-operations. To reach it, the bench counts clock edges after an accepted start. It then changes the neighbour inputs and fires a second start at fixed cycles inside the busy window. It then checks that the finished state matches a reference model fed only the inputs captured at the start, and that no second done pulse follows. Negative values whose product truncates by one LSB exercise the rounding rule. A chained run of several steps with changing inputs then shows that the rounding errors build up the same way in the block and in the reference model.

// File: rtl/ode_pe_pkg.sv
package ode_pe_pkg;

    localparam int SRC_N   = 10;
    localparam int SRC_W   = $clog2(SRC_N);
    localparam int ROM_N   = 5;
    localparam int ROM_AW  = $clog2(ROM_N);
    localparam int STATE_N = 2;
    localparam int STATE_AW = $clog2(STATE_N);
    localparam int OPND_N  = 4;

    // Constant table layout
    localparam logic [ROM_AW-1:0] K_CR = ROM_AW'(0);
    localparam logic [ROM_AW-1:0] K_CL = ROM_AW'(1);
    localparam logic [ROM_AW-1:0] K_DT = ROM_AW'(2);

    // State store layout
    localparam logic [STATE_AW-1:0] S_VOL  = STATE_AW'(0);
    localparam logic [STATE_AW-1:0] S_FLOW = STATE_AW'(1);

    typedef enum logic [SRC_W-1:0] {
        SRC_ZERO = 4'd0,
        SRC_ROM  = 4'd1,
        SRC_RAM  = 4'd2,
        SRC_TMP  = 4'd3,
        SRC_DF   = 4'd4,
        SRC_DV   = 4'd5,
        SRC_P1   = 4'd6,
        SRC_P2   = 4'd7,
        SRC_FA   = 4'd8,
        SRC_FB   = 4'd9
    } src_e;

    typedef enum logic [1:0] {
        DST_TMP,
        DST_DF,
        DST_DV,
        DST_RAM
    } dst_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FCR,
        ST_FCL,
        ST_PDIFF,
        ST_DF,
        ST_DV,
        ST_VINC,
        ST_VNEG,
        ST_VACC,
        ST_FINC,
        ST_FNEG,
        ST_FACC,
        ST_DONE
    } step_e;

    typedef struct packed {
        src_e                mul_a;
        src_e                mul_b;
        src_e                sub_a;
        src_e                sub_b;
        logic                use_mul;
        dst_e                dest;
        logic [ROM_AW-1:0]   rom_a;
        logic [STATE_AW-1:0] ram_a;
    } uop_t;

    function automatic uop_t uop_of(step_e s);
        uop_t u;
        u = '{mul_a: SRC_ZERO, mul_b: SRC_ZERO, sub_a: SRC_ZERO, sub_b: SRC_ZERO,
              use_mul: 1'b0, dest: DST_TMP, rom_a: K_CR, ram_a: S_VOL};
        case (s)
            ST_FCR:   begin u.mul_a = SRC_RAM; u.ram_a = S_FLOW; u.mul_b = SRC_ROM;
                            u.rom_a = K_CR; u.use_mul = 1'b1; u.dest = DST_TMP; end
            ST_FCL:   begin u.mul_a = SRC_TMP; u.mul_b = SRC_ROM; u.rom_a = K_CL;
                            u.use_mul = 1'b1; u.dest = DST_TMP; end
            ST_PDIFF: begin u.sub_a = SRC_P1; u.sub_b = SRC_P2; u.dest = DST_DF; end
            ST_DF:    begin u.sub_a = SRC_DF; u.sub_b = SRC_TMP; u.dest = DST_DF; end
            ST_DV:    begin u.sub_a = SRC_FA; u.sub_b = SRC_FB; u.dest = DST_DV; end
            ST_VINC:  begin u.mul_a = SRC_DV; u.mul_b = SRC_ROM; u.rom_a = K_DT;
                            u.use_mul = 1'b1; u.dest = DST_TMP; end
            ST_VNEG:  begin u.sub_a = SRC_ZERO; u.sub_b = SRC_TMP; u.dest = DST_TMP; end
            ST_VACC:  begin u.sub_a = SRC_RAM; u.ram_a = S_VOL; u.sub_b = SRC_TMP;
                            u.dest = DST_RAM; end
            ST_FINC:  begin u.mul_a = SRC_DF; u.mul_b = SRC_ROM; u.rom_a = K_DT;
                            u.use_mul = 1'b1; u.dest = DST_TMP; end
            ST_FNEG:  begin u.sub_a = SRC_ZERO; u.sub_b = SRC_TMP; u.dest = DST_TMP; end
            ST_FACC:  begin u.sub_a = SRC_RAM; u.ram_a = S_FLOW; u.sub_b = SRC_TMP;
                            u.dest = DST_RAM; end
            default:  ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/ode_const_rom.sv
module ode_const_rom
    import ode_pe_pkg::*;
#(
    parameter int W     = 32,
    parameter int CR_Q  = 32'sh0000_8000,
    parameter int CL_Q  = 32'sh0000_4000,
    parameter int DT_Q  = 32'sh0000_028F,
    parameter int V0_Q  = 32'sh0001_0000,
    parameter int F0_Q  = 32'sh0000_8000
) (
    input  logic [ROM_AW-1:0] addr_i,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      init_v_o,
    output logic [W-1:0]      init_f_o
);

    always_comb begin
        case (addr_i)
            K_CR:    data_o = W'(CR_Q);
            K_CL:    data_o = W'(CL_Q);
            K_DT:    data_o = W'(DT_Q);
            default: data_o = '0;
        endcase
    end

    assign init_v_o = W'(V0_Q);
    assign init_f_o = W'(F0_Q);

endmodule

// File: rtl/ode_state_ram.sv
module ode_state_ram
    import ode_pe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        init_v_i,
    input  logic [W-1:0]        init_f_i,
    input  logic [STATE_AW-1:0] addr_i,
    input  logic                we_i,
    input  logic [W-1:0]        wdata_i,
    output logic [W-1:0]        rdata_o,
    output logic [W-1:0]        vol_o,
    output logic [W-1:0]        flow_o
);

    logic [W-1:0] mem_q [STATE_N];
    logic [W-1:0] mem_d [STATE_N];
    logic [W-1:0] init_w [STATE_N];

    assign init_w[0] = init_v_i;
    assign init_w[1] = init_f_i;

    for (genvar i = 0; i < STATE_N; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (rst) begin
                mem_d[i] = init_w[i];
            end else if (we_i && addr_i == STATE_AW'(i)) begin
                mem_d[i] = wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_o = mem_q[addr_i];
    assign vol_o   = mem_q[S_VOL];
    assign flow_o  = mem_q[S_FLOW];

endmodule

// File: rtl/ode_opsel_mux.sv
module ode_opsel_mux
    import ode_pe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [SRC_N-1:0][W-1:0] srcs_i,
    input  src_e                    sel_i,
    output logic [W-1:0]            opnd_o
);

    always_comb begin
        opnd_o = '0;
        for (int k = 0; k < SRC_N; k++) begin
            if (sel_i == src_e'(k)) begin
                opnd_o = srcs_i[k];
            end
        end
    end

endmodule

// File: rtl/ode_seq_ctrl.sv
module ode_seq_ctrl
    import ode_pe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [W-1:0]        p1_i,
    input  logic [W-1:0]        p2_i,
    input  logic [W-1:0]        fa_i,
    input  logic [W-1:0]        fb_i,
    input  logic [W-1:0]        mul_res_i,
    input  logic [W-1:0]        sub_res_i,
    output src_e                sel_o [OPND_N],
    output logic [ROM_AW-1:0]   rom_addr_o,
    output logic [STATE_AW-1:0] ram_addr_o,
    output logic                ram_we_o,
    output logic [W-1:0]        tmp_o,
    output logic [W-1:0]        df_o,
    output logic [W-1:0]        dv_o,
    output logic [W-1:0]        p1_o,
    output logic [W-1:0]        p2_o,
    output logic [W-1:0]        fa_o,
    output logic [W-1:0]        fb_o,
    output logic                busy_o,
    output logic                done_o
);

    typedef struct packed {
        step_e        step;
        logic [W-1:0] tmp;
        logic [W-1:0] df;
        logic [W-1:0] dv;
        logic [W-1:0] p1;
        logic [W-1:0] p2;
        logic [W-1:0] fa;
        logic [W-1:0] fb;
    } ctrl_t;

    ctrl_t c_d, c_q;
    uop_t  uop;
    logic [W-1:0] res;

    always_comb begin
        uop = uop_of(c_q.step);
        res = uop.use_mul ? mul_res_i : sub_res_i;
        c_d = c_q;
        case (c_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.p1   = p1_i;
                    c_d.p2   = p2_i;
                    c_d.fa   = fa_i;
                    c_d.fb   = fb_i;
                    c_d.step = ST_FCR;
                end
            end
            ST_DONE: c_d.step = ST_IDLE;
            default: begin
                case (uop.dest)
                    DST_TMP: c_d.tmp = res;
                    DST_DF:  c_d.df  = res;
                    DST_DV:  c_d.dv  = res;
                    default: ;
                endcase
                c_d.step = step_e'(c_q.step + 4'd1);
            end
        endcase
        if (rst) begin
            c_d = '0;
            c_d.step = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign sel_o[0]   = uop.mul_a;
    assign sel_o[1]   = uop.mul_b;
    assign sel_o[2]   = uop.sub_a;
    assign sel_o[3]   = uop.sub_b;
    assign rom_addr_o = uop.rom_a;
    assign ram_addr_o = uop.ram_a;
    assign ram_we_o   = (uop.dest == DST_RAM) && (c_q.step != ST_IDLE) && (c_q.step != ST_DONE);
    assign tmp_o      = c_q.tmp;
    assign df_o       = c_q.df;
    assign dv_o       = c_q.dv;
    assign p1_o       = c_q.p1;
    assign p2_o       = c_q.p2;
    assign fa_o       = c_q.fa;
    assign fb_o       = c_q.fb;
    assign busy_o     = (c_q.step != ST_IDLE);
    assign done_o     = (c_q.step == ST_DONE);

endmodule

// File: rtl/ode_euler_pe.sv
module ode_euler_pe
    import ode_pe_pkg::*;
#(
    parameter int W     = 32,
    parameter int FRAC  = 16,
    parameter int CR_Q  = 32'sh0000_8000,
    parameter int CL_Q  = 32'sh0000_4000,
    parameter int DT_Q  = 32'sh0000_028F,
    parameter int V0_Q  = 32'sh0001_0000,
    parameter int F0_Q  = 32'sh0000_8000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] p1_i,
    input  logic [W-1:0] p2_i,
    input  logic [W-1:0] fa_i,
    input  logic [W-1:0] fb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] v_o,
    output logic [W-1:0] f_o
);

    localparam int PW = 2 * W;

    src_e                    sel [OPND_N];
    logic [W-1:0]            opnd [OPND_N];
    logic [SRC_N-1:0][W-1:0] srcs;
    logic [ROM_AW-1:0]       rom_addr;
    logic [STATE_AW-1:0]     ram_addr;
    logic                    ram_we;
    logic [W-1:0]            rom_q, ram_q, init_v, init_f;
    logic [W-1:0]            tmp, df, dv, p1c, p2c, fac, fbc;
    logic [W-1:0]            mul_res, sub_res;
    logic signed [PW-1:0]    prod;

    ode_seq_ctrl #(.W(W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .p1_i       (p1_i),
        .p2_i       (p2_i),
        .fa_i       (fa_i),
        .fb_i       (fb_i),
        .mul_res_i  (mul_res),
        .sub_res_i  (sub_res),
        .sel_o      (sel),
        .rom_addr_o (rom_addr),
        .ram_addr_o (ram_addr),
        .ram_we_o   (ram_we),
        .tmp_o      (tmp),
        .df_o       (df),
        .dv_o       (dv),
        .p1_o       (p1c),
        .p2_o       (p2c),
        .fa_o       (fac),
        .fb_o       (fbc),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    ode_const_rom #(
        .W(W), .CR_Q(CR_Q), .CL_Q(CL_Q), .DT_Q(DT_Q), .V0_Q(V0_Q), .F0_Q(F0_Q)
    ) rom_i (
        .addr_i   (rom_addr),
        .data_o   (rom_q),
        .init_v_o (init_v),
        .init_f_o (init_f)
    );

    ode_state_ram #(.W(W)) ram_i (
        .clk      (clk),
        .rst      (rst),
        .init_v_i (init_v),
        .init_f_i (init_f),
        .addr_i   (ram_addr),
        .we_i     (ram_we),
        .wdata_i  (sub_res),
        .rdata_o  (ram_q),
        .vol_o    (v_o),
        .flow_o   (f_o)
    );

    assign srcs[SRC_ZERO] = '0;
    assign srcs[SRC_ROM]  = rom_q;
    assign srcs[SRC_RAM]  = ram_q;
    assign srcs[SRC_TMP]  = tmp;
    assign srcs[SRC_DF]   = df;
    assign srcs[SRC_DV]   = dv;
    assign srcs[SRC_P1]   = p1c;
    assign srcs[SRC_P2]   = p2c;
    assign srcs[SRC_FA]   = fac;
    assign srcs[SRC_FB]   = fbc;

    for (genvar k = 0; k < OPND_N; k++) begin : g_opnd
        ode_opsel_mux #(.W(W)) mux_i (
            .srcs_i (srcs),
            .sel_i  (sel[k]),
            .opnd_o (opnd[k])
        );
    end

    // Shared multiplier: full product, arithmetic shift back to Q format
    assign prod    = PW'($signed(opnd[0])) * PW'($signed(opnd[1]));
    assign mul_res = W'(prod >>> FRAC);

    // Shared subtractor: wraps modulo 2^W
    assign sub_res = opnd[2] - opnd[3];

endmodule

// File: rtl/ode_euler_pe_chk.sv
module ode_euler_pe_chk #(
    parameter int W    = 32,
    parameter int V0_Q = 32'sh0001_0000,
    parameter int F0_Q = 32'sh0000_8000
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         ram_we,
    input logic [W-1:0] v_o,
    input logic [W-1:0] f_o
);

    // R1
    reset_init_chk: assert property (@(posedge clk)
        rst |=> (v_o == W'(V0_Q)) && (f_o == W'(F0_Q)) && !busy_o && !done_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> ($stable(v_o) && $stable(f_o)));

    // R6
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (busy_o && !done_o));

endmodule

bind ode_euler_pe ode_euler_pe_chk #(.W(W), .V0_Q(V0_Q), .F0_Q(F0_Q)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ram_we  (ram_we),
    .v_o     (v_o),
    .f_o     (f_o)
);

// File: tb/ode_euler_pe_tb.sv
module ode_euler_pe_tb_top;

    localparam int W    = 32;
    localparam int CR   = 32'sh0000_8000;
    localparam int CL   = 32'sh0000_4000;
    localparam int DT   = 32'sh0000_028F;
    localparam int V0   = 32'sh0001_0000;
    localparam int F0   = 32'sh0000_8000;
    localparam int LAT  = 12;
    localparam int WDOG = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] p1, p2, fa, fb;
    logic         busy, done;
    logic [W-1:0] v, f;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic signed [W-1:0] mv, mf;

    always #2 clk = ~clk;

    ode_euler_pe #(.W(W), .FRAC(16), .CR_Q(CR), .CL_Q(CL), .DT_Q(DT),
                   .V0_Q(V0), .F0_Q(F0)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .p1_i(p1), .p2_i(p2),
        .fa_i(fa), .fb_i(fb), .busy_o(busy), .done_o(done), .v_o(v), .f_o(f)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic signed [W-1:0] qmul(logic signed [W-1:0] a, logic signed [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = (2*W)'(a) * (2*W)'(b);
        return p[W+15:16];
    endfunction

    task automatic model_step(input logic [W-1:0] ip1, ip2, ifa, ifb);
        logic signed [W-1:0] dfv, dvv;
        dvv = ifa - ifb;
        dfv = (ip1 - ip2) - qmul(qmul(mf, W'(CR)), W'(CL));
        mv  = mv + qmul(dvv, W'(DT));
        mf  = mf + qmul(dfv, W'(DT));
    endtask

    task automatic check(input string req, input logic [W-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mv = W'(V0); mf = W'(F0);
    endtask

    // Pulses start with the given inputs, returns cycles to done
    task automatic launch(input logic [W-1:0] ip1, ip2, ifa, ifb, output int lat);
        @(negedge clk);
        p1 = ip1; p2 = ip2; fa = ifa; fb = ifb; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 1;
        while (lat < 40) begin
            @(negedge clk);
            if (done) break;
            @(posedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 volume", v, W'(V0));
        check("R1 flow", f, W'(F0));
        check("R1 busy", W'(busy), '0);
        check("R1 done", W'(done), '0);
    endtask

    task automatic t_single();
        int lat;
        logic [W-1:0] vb, fb0;
        do_reset();
        launch(32'sh0002_0000, 32'sh0000_8000, 32'sh0001_8000, 32'sh0000_4000, lat);
        model_step(32'sh0002_0000, 32'sh0000_8000, 32'sh0001_8000, 32'sh0000_4000);
        check("R5 latency", W'(lat), W'(LAT));
        check("R2 volume", v, mv);
        check("R3 flow", f, mf);
        vb = v; fb0 = f;
        @(negedge clk);
        check("R5 done one cycle", W'(done), '0);
        check("R5 busy cleared", W'(busy), '0);
        repeat (5) @(negedge clk);
        check("R9 volume idle", v, vb);
        check("R9 flow idle", f, fb0);
    endtask

    task automatic t_negative();
        int lat;
        do_reset();
        // flow difference of -1 LSB: product truncates to -1 LSB
        launch(32'shFFFE_0000, 32'sh0003_0000, 32'sh0000_0000, 32'sh0000_0001, lat);
        model_step(32'shFFFE_0000, 32'sh0003_0000, 32'sh0000_0000, 32'sh0000_0001);
        check("R4 volume round down", v, W'(V0) - 32'd1);
        check("R4 flow negative", f, mf);
    endtask

    task automatic t_capture();
        do_reset();
        @(negedge clk);
        p1 = 32'sh0001_0000; p2 = 32'sh0000_2000; fa = 32'sh0000_C000; fb = 32'sh0001_4000;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (3) @(negedge clk);
        p1 = 32'sh7000_0000; p2 = 32'sh9000_0000; fa = 32'sh1234_5678; fb = 32'shDEAD_0000;
        while (!done) @(negedge clk);
        model_step(32'sh0001_0000, 32'sh0000_2000, 32'sh0000_C000, 32'sh0001_4000);
        check("R7 volume", v, mv);
        check("R7 flow", f, mf);
    endtask

    task automatic t_busy_start();
        int seen;
        do_reset();
        @(negedge clk);
        p1 = 32'sh0000_4000; p2 = 32'sh0000_1000; fa = 32'sh0000_2000; fb = 32'sh0000_1000;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (4) @(negedge clk);
        p1 = 32'sh0005_0000; fa = 32'sh0009_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        model_step(32'sh0000_4000, 32'sh0000_1000, 32'sh0000_2000, 32'sh0000_1000);
        check("R6 volume", v, mv);
        check("R6 flow", f, mf);
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (done || busy) seen++;
        end
        check("R6 no extra step", W'(seen), '0);
        check("R6 volume after", v, mv);
    endtask

    task automatic t_reset_mid();
        do_reset();
        @(negedge clk);
        fa = 32'sh0004_0000; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid volume", v, W'(V0));
        check("R1 mid flow", f, W'(F0));
        check("R1 mid busy", W'(busy), '0);
    endtask

    task automatic t_chain();
        int lat;
        logic [W-1:0] a, b, c, d;
        do_reset();
        for (int n = 0; n < 20; n++) begin
            a = W'(n * 32'sh0000_3100 - 32'sh0001_0000);
            b = W'(32'sh0000_8000 - n * 32'sh0000_0777);
            c = W'(n * n * 32'sh0000_0123);
            d = W'(32'sh0000_9000 + n * 32'sh0000_0555);
            launch(a, b, c, d, lat);
            model_step(a, b, c, d);
            if (n == 0 || n == 9 || n == 19) begin
                check("R8 chained volume", v, mv);
                check("R8 chained flow", f, mf);
                check("R5 chained latency", W'(lat), W'(LAT));
            end else if (v !== mv || f !== mf) begin
                check("R8 chained state", {v[15:0], f[15:0]}, {mv[15:0], mf[15:0]});
            end
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        p1 = '0; p2 = '0; fa = '0; fb = '0;
        mv = W'(V0); mf = W'(F0);
        t_reset();
        t_single();
        t_negative();
        t_capture();
        t_busy_start();
        t_reset_mid();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule